// File: doc/BRIEF.md
# DMA Interrupt Mask and Completion Counter

This block holds the interrupt and status registers that sit beside a DMA engine. Eight event inputs, one per interrupt source, set sticky flags in an interrupt status register. Software acknowledges a flag by writing a 1 to it. A separate mask register decides which flags may raise the level interrupt output. Software changes that mask only through two write-only strobe registers: one unmasks the sources it names, the other masks them.

A small completion counter counts DONE events. It goes down by one each time software acknowledges a DONE flag that was actually set. Software can also clear it directly by writing 1s over its field. The same status word carries a read-only busy bit taken from the engine. All registers sit behind one simple single-cycle read/write port with combinational read data.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the interrupt status reads 0, the mask reads 0xFF (every source masked), the completion counter reads 0 and `irq_o` is low.
- R2: A pulse on `evt_i[i]` sets status bit i at the next clock edge. Bit assignment, high to low: 7 FIFO overflow, 6 illegal register access, 5 threshold hit, 4 memory timeout, 3 stream timeout, 2 bus response error, 1 DONE, 0 memory-side done.
- R3: Writing the interrupt status register (word address 1) clears each bit written as 1 and leaves each bit written as 0. When an event sets a bit in the same cycle as a write clears it, the bit ends up set.
- R4: A write to the enable strobe (address 2) clears the mask bits written as 1. A write to the disable strobe (address 3) sets them. 0 bits in either write change nothing. Both strobes read as 0. The mask (address 4, bits 7:0) ignores direct writes.
- R5: `irq_o` is high exactly when some status bit is set while its mask bit is 0. It follows each status, event or mask change from the clock edge that applies it.
- R6: The completion counter, at bits 15:13 of the engine status word (address 0), increments on every `evt_i[1]` pulse and wraps from 7 to 0.
- R7: A status write that clears a DONE bit which was set decrements the counter by one, wrapping from 0 to 7. A 1 written to DONE while DONE is clear does not decrement it. An event on DONE in the same cycle as its acknowledgement leaves the counter unchanged.
- R8: A write to address 0 clears each counter bit written as 1 and keeps the rest. A DONE event in the same cycle then adds one to the result. Bit 0 of address 0 reads `busy_i`. Every other bit of that word reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event pulses, one per interrupt source |
| busy_i | input | 1 | Engine busy level, shown in the status word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench goes after several corner cases. The first is an event arriving in the same cycle as the acknowledgement of its own flag. A design where the clear wins would lose the interrupt. The second is acknowledging DONE while it is already clear, where a careless decrement would make the counter drift. The bench also drives the counter across both wrap points and clears it partially with a mixed bit pattern. A wrong design would saturate there, or wipe the whole field. Finally, the bench writes the mask register directly and reads the strobes back, so a mask that accepts plain writes, or strobes that keep their own state, would show up as wrong read data or a wrong interrupt level.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NSRC     = 8,
  parameter int CNT_W    = 3,
  parameter int CNT_LSB  = 13,
  parameter int DONE_IDX = 1,
  parameter int AW       = 3,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic          busy_i,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_ENG  = AW'(0);
  localparam logic [AW-1:0] A_STS  = AW'(1);
  localparam logic [AW-1:0] A_UNM  = AW'(2);
  localparam logic [AW-1:0] A_MSK  = AW'(3);
  localparam logic [AW-1:0] A_MASK = AW'(4);
  localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

  logic [NSRC-1:0]  int_sts, int_mask;
  logic [CNT_W-1:0] done_cnt;

  wire wr_eng = reg_we && reg_addr == A_ENG;
  wire wr_sts = reg_we && reg_addr == A_STS;
  wire wr_unm = reg_we && reg_addr == A_UNM;
  wire wr_msk = reg_we && reg_addr == A_MSK;

  wire [NSRC-1:0]  wbits   = reg_wdata[NSRC-1:0];
  wire [CNT_W-1:0] cnt_clr = wr_eng ? reg_wdata[CNT_MSB:CNT_LSB] : '0;
  wire             cnt_inc = evt_i[DONE_IDX];
  wire             cnt_dec = wr_sts && wbits[DONE_IDX] && int_sts[DONE_IDX];

  wire unused_wdata = &{1'b0, reg_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_sts  <= '0;
      int_mask <= '1;
      done_cnt <= '0;
    end else begin
      int_sts  <= (int_sts & ~(wr_sts ? wbits : '0)) | evt_i;
      int_mask <= (int_mask & ~(wr_unm ? wbits : '0)) | (wr_msk ? wbits : '0);
      done_cnt <= (done_cnt & ~cnt_clr) + CNT_W'(cnt_inc) - CNT_W'(cnt_dec);
    end
  end

  assign irq_o = |(int_sts & ~int_mask);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENG: begin
        reg_rdata[CNT_MSB:CNT_LSB] = done_cnt;
        reg_rdata[0] = busy_i;
      end
      A_STS:  reg_rdata[NSRC-1:0] = int_sts;
      A_MASK: reg_rdata[NSRC-1:0] = int_mask;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module dma_irq_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int CNT_W = 3,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_i,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic            irq_o,
  input logic [NSRC-1:0] int_sts,
  input logic [NSRC-1:0] int_mask,
  input logic [CNT_W-1:0] done_cnt
);
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((int_sts & $past(evt_i)) == $past(evt_i)));
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && evt_i == '0) |=> ((int_sts & $past(reg_wdata[NSRC-1:0])) == '0));
  assert_unmask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2) |=> ((int_mask & $past(reg_wdata[NSRC-1:0])) == '0));
  assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3) |=> ((int_mask & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])));
  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == 3'd2 || reg_addr == 3'd3)) |=> $stable(int_mask));
  assert_strobe_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2 || reg_addr == 3'd3) |-> reg_rdata == '0);
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mask == '1) |-> !irq_o);
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i[1] && !reg_we) |=> $stable(done_cnt));
  assert_cnt_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && reg_wdata[1] && int_sts[1] && !evt_i[1]) |=> (done_cnt == $past(done_cnt) - 1'b1));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NSRC(NSRC), .CNT_W(CNT_W), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
  .int_sts(int_sts), .int_mask(int_mask), .done_cnt(done_cnt));

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;
  logic clk = 0, rst_n = 0, busy = 0, we = 0, irq;
  logic [7:0] evt = 0;
  logic [2:0] addr = 0;
  logic [31:0] wd = 0, rd;
  int checks = 0, fails = 0;
  logic [7:0] m_sts, m_mask;
  logic [2:0] m_cnt;

  always #10 clk = ~clk;

  dma_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .evt_i(evt), .busy_i(busy), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wd), .reg_rdata(rd), .irq_o(irq));

  function automatic logic [31:0] exp_read(input logic [2:0] a, input logic b);
    case (a)
      3'd0: return {16'd0, m_cnt, 12'd0, b};
      3'd1: return {24'd0, m_sts};
      3'd4: return {24'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] e, input logic w, input logic [2:0] a,
                     input logic [31:0] d, input logic b, input string tag);
    logic inc, dec;
    logic [2:0] clr;
    evt = e; we = w; addr = a; wd = d; busy = b;
    #1;
    check({tag, " irq R5"}, {31'd0, irq}, {31'd0, |(m_sts & ~m_mask)});
    if (!w) check({tag, " read"}, rd, exp_read(a, b));
    @(posedge clk);
    inc = e[1];
    dec = w && a == 3'd1 && d[1] && m_sts[1];
    clr = (w && a == 3'd0) ? d[15:13] : 3'd0;
    m_cnt = (m_cnt & ~clr) + {2'd0, inc} - {2'd0, dec};
    m_sts = (m_sts & ~((w && a == 3'd1) ? d[7:0] : 8'd0)) | e;
    if (w && a == 3'd2) m_mask = m_mask & ~d[7:0];
    if (w && a == 3'd3) m_mask = m_mask | d[7:0];
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    cyc(8'd0, 1'b0, a, 32'd0, busy, tag);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    m_sts = 0; m_mask = 8'hFF; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_chk(3'd0, "R1 counter");
    rd_chk(3'd1, "R1 status");
    rd_chk(3'd4, "R1 mask");
    check("R1 irq", {31'd0, irq}, 32'd0);

    cyc(8'h00, 1, 3'd4, 32'h0, 0, "R4 direct mask write");
    rd_chk(3'd4, "R4 mask ignores write");
    cyc(8'h00, 1, 3'd2, 32'h02, 0, "R4 unmask DONE");
    rd_chk(3'd2, "R4 enable reads zero");
    rd_chk(3'd3, "R4 disable reads zero");
    cyc(8'h02, 0, 3'd0, 0, 1, "R2 DONE event");
    rd_chk(3'd1, "R2 status bit1");
    check("R5 irq on unmasked", {31'd0, irq}, 32'd1);
    cyc(8'h02, 1, 3'd1, 32'h02, 0, "R3 set wins");
    rd_chk(3'd1, "R3 set wins status");
    rd_chk(3'd0, "R7 counter unchanged on set+ack");
    cyc(8'h00, 1, 3'd1, 32'h02, 0, "R7 ack DONE");
    rd_chk(3'd0, "R7 decremented");
    cyc(8'h00, 1, 3'd1, 32'h02, 0, "R7 ack clear DONE");
    rd_chk(3'd0, "R7 no decrement when clear");
    for (int i = 0; i < 9; i++) cyc(8'h02, 0, 3'd1, 0, 0, "R6 count up");
    rd_chk(3'd0, "R6 wrap up");
    cyc(8'h00, 1, 3'd0, 32'h0000_A001, 1, "R8 partial clear");
    rd_chk(3'd0, "R8 counter after clear");
    cyc(8'h02, 1, 3'd0, 32'h0000_E000, 1, "R8 clear plus event");
    rd_chk(3'd0, "R8 counter one");
    cyc(8'h00, 1, 3'd1, 32'h02, 0, "R7 ack to zero");
    cyc(8'h02, 0, 3'd0, 0, 0, "R7 set again");
    cyc(8'h00, 1, 3'd0, 32'h0000_E000, 0, "R7 clear counter");
    cyc(8'h00, 1, 3'd1, 32'h02, 0, "R7 ack at zero");
    rd_chk(3'd0, "R7 wrap down");
    cyc(8'h00, 1, 3'd3, 32'hFF, 0, "R4 mask all");
    check("R5 irq masked", {31'd0, irq}, 32'd0);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] e;
      logic [2:0] a;
      logic [31:0] d;
      e = ($urandom % 4 == 0) ? (8'd1 << ($urandom % 8)) : 8'd0;
      if ($urandom % 6 == 0) e[1] = 1'b1;
      a = 3'($urandom % 6);
      d = $urandom;
      cyc(e, 1'($urandom % 2), a, d, 1'($urandom % 2), "R2 R3 R4 R6 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule